// File: doc/BRIEF.md
# Video Output Range Clamp

This block limits every component of a three-component pixel to a legal video range just before the pixel leaves the display pipeline. Each component is a 12-bit word. A clamp enable and a 3-bit format code pick the range. Three codes give fixed limited-range presets, one for each content depth (8, 10 and 12 bits per component). A fourth code gives a programmable mode in which the red, green and blue components each have their own lower and upper bounds. Every other case passes the pixel through at full range.

Pixels arrive and leave on valid/ready streams with a single register stage in between. The output side may apply back-pressure. While `out_valid` is high and `out_ready` is low, the output word is held and `in_ready` drops. `in_ready` is high whenever the output stage is empty or is being emptied in the same cycle, so a stream that is never stalled runs at one pixel per clock. The enable, the format code and the programmable bounds are sampled in the cycle the pixel is accepted. A reconfiguration is therefore expected to clear the enable first, change the mode, and then set the enable again.

Top module: `pixel_range_clamp`

## Requirements
- R1: When `clamp_en` is 0, every accepted pixel appears unchanged on `out_pix`, whatever the format code.
- R2: Format codes 0, 4, 5 and 6 clamp nothing: the pixel passes unchanged even with `clamp_en` set.
- R3: Code 1 (8-bit content) bounds each component to 0x100..0xEBF.
- R4: Code 2 (10-bit content) bounds each component to 0x100..0xEB3.
- R5: Code 3 (12-bit content) bounds each component to 0x100..0xEB0.
- R6: Code 7 bounds red by `lo_r`/`hi_r`, green by `lo_g`/`hi_g` and blue by `lo_b`/`hi_b`, each independently of the others.
- R7: In any active mode, a component whose lower bound exceeds its upper bound is output as the lower bound.
- R8: A pixel accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_pix` with `out_valid` high after that edge. Pixels leave in the order they were accepted, and none are lost or duplicated.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_pix` and `out_valid` hold. `in_ready` equals `!out_valid || out_ready`.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

The pixel word packs red in bits [35:24], green in [23:12] and blue in [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pix | input | 36 | Input pixel {R,G,B} |
| clamp_en | input | 1 | Clamp enable |
| fmt_code | input | 3 | Range format code |
| lo_r | input | 12 | Programmable red lower bound |
| hi_r | input | 12 | Programmable red upper bound |
| lo_g | input | 12 | Programmable green lower bound |
| hi_g | input | 12 | Programmable green upper bound |
| lo_b | input | 12 | Programmable blue lower bound |
| hi_b | input | 12 | Programmable blue upper bound |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output |
| out_pix | output | 36 | Clamped pixel {R,G,B} |

## Verification
The assertions assume that the upstream source follows the stream rules. They also assume that the mode and bound pins are driven to known values whenever `in_valid` is high, because the range checks in each lane assess the bounds in effect for the accepted pixel. The stimulus changes the mode and the bounds together with each pixel, always with defined values. It includes inverted bounds and values at, just inside and just outside each preset limit. Back-pressure follows a pseudo-random ready pattern, so some pixels are held for several cycles while the next one waits at the input.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  localparam int unsigned NCH = 3;

  typedef enum logic [2:0] {
    FMT_NONE  = 3'd0,
    FMT_LIM8  = 3'd1,
    FMT_LIM10 = 3'd2,
    FMT_LIM12 = 3'd3,
    FMT_PROG  = 3'd7
  } fmt_e;

  // Limited-range lower bound on a CW-bit MSB-aligned word.
  function automatic int unsigned preset_lo(input int unsigned cw);
    return 16 << (cw - 8);
  endfunction

  // Limited-range upper bound for content of depth d; the bits below d are filled.
  function automatic int unsigned preset_hi(input int unsigned cw, input int unsigned d);
    return (235 << (cw - 8)) | ((1 << (cw - d)) - 1);
  endfunction
endpackage

// File: rtl/clamp_bound_sel.sv
module clamp_bound_sel
  import clamp_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic              enable,
  input  logic [2:0]        fmt_code,
  input  logic [NCH*CW-1:0] prog_lo,
  input  logic [NCH*CW-1:0] prog_hi,
  output logic              active,
  output logic [NCH*CW-1:0] lo,
  output logic [NCH*CW-1:0] hi
);
  localparam logic [CW-1:0] LO_P   = CW'(preset_lo(CW));
  localparam logic [CW-1:0] HI_P8  = CW'(preset_hi(CW, 8));
  localparam logic [CW-1:0] HI_P10 = CW'(preset_hi(CW, 10));
  localparam logic [CW-1:0] HI_P12 = CW'(preset_hi(CW, 12));

  fmt_e fmt;
  assign fmt = fmt_e'(fmt_code);

  always_comb begin
    active = 1'b0;
    lo     = '0;
    hi     = '1;
    if (enable) begin
      case (fmt)
        FMT_LIM8:  begin active = 1'b1; lo = {NCH{LO_P}}; hi = {NCH{HI_P8}};  end
        FMT_LIM10: begin active = 1'b1; lo = {NCH{LO_P}}; hi = {NCH{HI_P10}}; end
        FMT_LIM12: begin active = 1'b1; lo = {NCH{LO_P}}; hi = {NCH{HI_P12}}; end
        FMT_PROG:  begin active = 1'b1; lo = prog_lo;     hi = prog_hi;       end
        default:   active = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/clamp_lane.sv
module clamp_lane #(
  parameter int unsigned CW = 12
) (
  input  logic          active,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic [CW-1:0] y
);
  logic [CW-1:0] top_cut;

  always_comb begin
    top_cut = (x > hi) ? hi : x;
    if (!active)          y = x;
    else if (top_cut < lo) y = lo;
    else                   y = top_cut;
  end

  always_comb begin
    if (active && (lo <= hi))
      assert_in_range_R6 : assert ((y >= lo) && (y <= hi));
    if (active && (lo > hi))
      assert_inverted_R7 : assert (y == lo);
  end
endmodule

// File: rtl/pixel_range_clamp.sv
module pixel_range_clamp
  import clamp_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*CW-1:0] in_pix,
  input  logic              clamp_en,
  input  logic [2:0]        fmt_code,
  input  logic [CW-1:0]     lo_r,
  input  logic [CW-1:0]     hi_r,
  input  logic [CW-1:0]     lo_g,
  input  logic [CW-1:0]     hi_g,
  input  logic [CW-1:0]     lo_b,
  input  logic [CW-1:0]     hi_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH*CW-1:0] out_pix
);
  localparam int unsigned PW = NCH * CW;

  logic          active;
  logic [PW-1:0] lo_all, hi_all, clamped;
  logic          take;

  clamp_bound_sel #(.CW(CW)) u_bounds (
    .enable  (clamp_en),
    .fmt_code(fmt_code),
    .prog_lo ({lo_r, lo_g, lo_b}),
    .prog_hi ({hi_r, hi_g, hi_b}),
    .active  (active),
    .lo      (lo_all),
    .hi      (hi_all)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    clamp_lane #(.CW(CW)) u_lane (
      .active(active),
      .x     (in_pix[c*CW +: CW]),
      .lo    (lo_all[c*CW +: CW]),
      .hi    (hi_all[c*CW +: CW]),
      .y     (clamped[c*CW +: CW])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_pix   <= clamped;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));
  assert_ready_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  assert_accept_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_drain_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/test_pixel_range_clamp.sv
module test_pixel_range_clamp;
  localparam int CW = 12;
  localparam int PW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [PW-1:0] in_pix = '0;
  logic clamp_en = 1'b0;
  logic [2:0] fmt_code = 3'd0;
  logic [CW-1:0] lo_r = 12'h010, hi_r = 12'hFEF, lo_g = 12'h010, hi_g = 12'hFEF;
  logic [CW-1:0] lo_b = 12'h010, hi_b = 12'hFEF;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [PW-1:0] out_pix;

  int checks = 0;
  int failures = 0;
  logic [PW-1:0] exp_q[$];
  string tag_q[$];
  int sent = 0;
  int got = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pixel_range_clamp i_pixel_range_clamp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .clamp_en(clamp_en), .fmt_code(fmt_code),
    .lo_r(lo_r), .hi_r(hi_r), .lo_g(lo_g), .hi_g(hi_g), .lo_b(lo_b), .hi_b(hi_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] ref_comp(input logic [CW-1:0] x, input bit act,
                                             input logic [CW-1:0] l, input logic [CW-1:0] h);
    if (!act) return x;
    if (l > h) return l;
    if (x < l) return l;
    if (x > h) return h;
    return x;
  endfunction

  function automatic logic [PW-1:0] ref_pix(input logic [PW-1:0] p, input bit en,
      input logic [2:0] f, input logic [CW-1:0] lr, input logic [CW-1:0] hr,
      input logic [CW-1:0] lg, input logic [CW-1:0] hg,
      input logic [CW-1:0] lb, input logic [CW-1:0] hb);
    logic [CW-1:0] l[3], h[3];
    bit a;
    logic [PW-1:0] r;
    a = en && (f inside {3'd1, 3'd2, 3'd3, 3'd7});
    for (int c = 0; c < 3; c++) begin
      l[c] = 12'h100;
      h[c] = (f == 3'd1) ? 12'hEBF : (f == 3'd2) ? 12'hEB3 : 12'hEB0;
    end
    if (f == 3'd7) begin
      l[2] = lr; h[2] = hr; l[1] = lg; h[1] = hg; l[0] = lb; h[0] = hb;
    end
    for (int c = 0; c < 3; c++) r[c*CW +: CW] = ref_comp(p[c*CW +: CW], a, l[c], h[c]);
    return r;
  endfunction

  task automatic send(input logic [PW-1:0] p, input bit en, input logic [2:0] f,
                      input logic [CW-1:0] lr, input logic [CW-1:0] hr,
                      input logic [CW-1:0] lg, input logic [CW-1:0] hg,
                      input logic [CW-1:0] lb, input logic [CW-1:0] hb, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_pix = p; clamp_en = en; fmt_code = f;
    lo_r = lr; hi_r = hr; lo_g = lg; hi_g = hg; lo_b = lb; hi_b = hb;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(ref_pix(p, en, f, lr, hr, lg, hg, lb, hb));
    tag_q.push_back(req);
    sent++;
    @(posedge clk);
    #0.5;
    in_valid = 1'b0;
  endtask

  task automatic send_std(input logic [PW-1:0] p, input bit en, input logic [2:0] f,
                          input string req);
    send(p, en, f, 12'h010, 12'hFEF, 12'h010, 12'hFEF, 12'h010, 12'hFEF, req);
  endtask

  // ready pattern, updated exactly at the falling edge
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = stall_en ? lfsr[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit held = 1'b0;
    logic [PW-1:0] held_pix = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (held) check(out_valid && out_pix == held_pix, "R9 hold", out_pix, held_pix);
        check(in_ready == (!out_valid || out_ready), "R9 in_ready", {35'd0, in_ready},
              {35'd0, (!out_valid || out_ready)});
        held = out_valid && !out_ready;
        held_pix = out_pix;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected output", out_pix, '0);
          end else begin
            logic [PW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_pix == e, t, out_pix, e);
            got++;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R8 watchdog", '0, '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] s = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R10 out_valid", {35'd0, out_valid}, '0);
    check(in_ready == 1'b1, "R10 in_ready", {35'd0, in_ready}, {35'd0, 1'b1});
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1: enable clear, every code passes
    for (int f = 0; f < 8; f++) send_std({12'h000, 12'hFFF, 12'h0FF}, 1'b0, 3'(f), "R1");
    // R2: reserved / none codes pass with enable set
    send_std({12'h000, 12'hFFF, 12'h050}, 1'b1, 3'd0, "R2");
    for (int f = 4; f < 7; f++) send_std({12'h001, 12'hFFE, 12'hEC0}, 1'b1, 3'(f), "R2");
    // R3 / R4 / R5 preset boundaries
    send_std({12'h0FF, 12'h100, 12'hEBF}, 1'b1, 3'd1, "R3");
    send_std({12'hEC0, 12'h000, 12'h800}, 1'b1, 3'd1, "R3");
    send_std({12'hEB3, 12'hEB4, 12'h0FF}, 1'b1, 3'd2, "R4");
    send_std({12'hEBF, 12'h101, 12'h000}, 1'b1, 3'd2, "R4");
    send_std({12'hEB0, 12'hEB1, 12'h100}, 1'b1, 3'd3, "R5");
    send_std({12'hFFF, 12'h0FF, 12'h7A5}, 1'b1, 3'd3, "R5");
    // R6 programmable, default and distinct per-component bounds
    send_std({12'h000, 12'hFFF, 12'h010}, 1'b1, 3'd7, "R6");
    send({12'h005, 12'h900, 12'hFFF}, 1'b1, 3'd7,
         12'h020, 12'h300, 12'h400, 12'h800, 12'h000, 12'hA00, "R6");
    send({12'h400, 12'h200, 12'h050}, 1'b1, 3'd7,
         12'h020, 12'h300, 12'h400, 12'h800, 12'h100, 12'hA00, "R6");
    // R7 inverted bounds
    send({12'h000, 12'h500, 12'hFFF}, 1'b1, 3'd7,
         12'h800, 12'h100, 12'h300, 12'h200, 12'h555, 12'h554, "R7");
    // R8 / R9: random stream under back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      send({s[11:0], s[23:12], s[31:20]}, s[3], 3'(s[7:5]),
           12'(s[19:8]), 12'(s[31:20]), 12'h200, 12'hC00, 12'(s[11:0]), 12'hFEF, "R8");
    end
    stall_en = 1'b0;
    repeat (20) @(posedge clk);
    check(got == sent && exp_q.size() == 0, "R8 count", PW'(got), PW'(sent));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule